// File: doc/BRIEF.md
# Programmable Event Counter Bank

This block is a bank of general-purpose event counters for a processor core. Every cycle the core presents a small set of event lanes, each carrying a valid bit, an 8-bit event code and an 8-bit qualifier mask, together with one flag that says whether the core is in kernel or user mode. Each counter owns an event-select register that names the code and qualifier mask it looks for, the privilege levels it accepts, a local enable and an interrupt-on-overflow choice. A counter advances by one in any cycle where at least one valid lane matches and both its local enable and its bit in the shared global-enable register are set.

Software reaches the bank through a single-cycle register port: a write strobe with address and 64-bit data, a combinational read bus that always reflects the addressed register, and an error flag that refuses illegal writes in the same cycle. Counter writes take the low 32 bits of the data and sign-extend them, so software can preload a negative count and receive an overflow after a chosen number of events. When a counter wraps from all ones to zero, its overflow status bit is set; if its event-select register asks for it, an interrupt request is raised until software clears the status bit.

Address map (5-bit address): 0x00+i counter i, 0x08+i event-select i, 0x10 global enable (bit i enables counter i), 0x11 overflow status (read only), 0x12 status clear (write ones to clear, reads zero).

Top module: `pmu_ctr_bank`

## Requirements
- R1: After reset every counter, event-select register, global-enable bit and status bit is zero, and irq is low.
- R2: A counter matches a lane only if that lane is valid, its code equals event-select bits 7:0 and its qualifier equals event-select bits 15:8.
- R3: A counter counts only when event-select bit 22 (local enable) and its global-enable bit are both set; otherwise it holds.
- R4: Event-select bit 16 permits counting while priv_kernel is 0 and bit 17 permits counting while priv_kernel is 1; a cleared bit excludes that mode.
- R5: A counter write loads the sign extension of wdata[31:0] to the counter width, ignoring wdata[63:32]; a write wins over an event in the same cycle.
- R6: A counter read returns its CTR_W bits with all bits above CTR_W (48 by default) reading zero.
- R7: An event-select write with any of bits 63:32 or bit 21 set raises reg_err and leaves the register unchanged; any other write is accepted and reads back exactly, including bits 18, 19 and 23 to 31.
- R8: Event-select bit 19 is stored but has no effect on counting.
- R9: An increment from all ones wraps the counter to zero and sets its status bit (address 0x11, port ovf_status) from the next cycle.
- R10: irq is high exactly while a set status bit belongs to a counter whose event-select bit 20 is set; with bit 20 clear an overflow sets status only.
- R11: Writing ones to 0x12 clears those status bits; writes to 0x11, to global enable with bits at or above NUM_CTR, or to unimplemented addresses raise reg_err and change nothing.
- R12: Several matching lanes in one cycle advance a counter by exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for reg_addr (combinational) |
| reg_err | output | 1 | Current write is refused |
| evt_vld | input | LANES | Per-lane event valid |
| evt_code | input | 8*LANES | Per-lane event code |
| evt_umask | input | 8*LANES | Per-lane qualifier mask |
| priv_kernel | input | 1 | 1 = kernel mode, 0 = user mode |
| ovf_status | output | NUM_CTR | Overflow status bits |
| irq | output | 1 | Overflow interrupt request |

## Verification
The bench aims at the wrap from all ones to zero, where a design that compares against the wrong width would never flag overflow or flag it one event early, and at sign extension, where a zero-extending design would read a preloaded -1 back as 0xFFFFFFFF. It drives a matching code with a wrong qualifier, and a matching lane with its valid low, to catch a matcher that ignores either field. It writes forbidden event-select bits and reads the old value back, catching a design that stores before it checks, and it collides a counter write with an event to catch an increment that overrides software.

// File: rtl/pmu_ctr_pkg.sv
package pmu_ctr_pkg;

    // Event-select field positions
    localparam int SEL_CODE_LO  = 0;
    localparam int SEL_UMASK_LO = 8;
    localparam int SEL_USR      = 16;
    localparam int SEL_OS       = 17;
    localparam int SEL_EDGE     = 18;
    localparam int SEL_PIN      = 19;
    localparam int SEL_INT      = 20;
    localparam int SEL_RSVD     = 21;
    localparam int SEL_EN       = 22;
    localparam int SEL_INV      = 23;

    localparam int SEL_W   = 32;
    localparam int DATA_W  = 64;

    typedef enum logic [1:0] {
        RGN_CTR   = 2'd0,
        RGN_SEL   = 2'd1,
        RGN_GLOB  = 2'd2,
        RGN_NONE  = 2'd3
    } region_e;

    localparam logic [2:0] SUB_GLB_EN  = 3'd0;
    localparam logic [2:0] SUB_STATUS  = 3'd1;
    localparam logic [2:0] SUB_CLEAR   = 3'd2;

endpackage

// File: rtl/pmu_evt_match.sv
module pmu_evt_match #(
    parameter int LANES = 2
) (
    input  logic [7:0]         sel_code,
    input  logic [7:0]         sel_umask,
    input  logic               sel_usr,
    input  logic               sel_os,
    input  logic               sel_en,
    input  logic [LANES-1:0]   evt_vld,
    input  logic [8*LANES-1:0] evt_code,
    input  logic [8*LANES-1:0] evt_umask,
    input  logic               priv_kernel,
    output logic               hit
);
    logic [LANES-1:0] lane_hit;
    logic             priv_ok;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_hit[l] = evt_vld[l]
                          && (evt_code[8*l +: 8]  == sel_code)
                          && (evt_umask[8*l +: 8] == sel_umask);
    end

    assign priv_ok = priv_kernel ? sel_os : sel_usr;
    assign hit     = sel_en && priv_ok && (|lane_hit);

endmodule

// File: rtl/pmu_ctr_slice.sv
module pmu_ctr_slice #(
    parameter int CTR_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             glb_en,
    input  logic             wr,
    input  logic [31:0]      wval,
    output logic [CTR_W-1:0] cnt,
    output logic             ovf
);
    typedef struct packed {
        logic [CTR_W-1:0] cnt;
    } slice_t;

    slice_t st_d, st_q;
    logic   inc;
    logic   at_max;

    assign inc    = hit && glb_en;
    assign at_max = &st_q.cnt;

    always_comb begin
        st_d = st_q;
        ovf  = 1'b0;
        if (wr) begin
            st_d.cnt = {{(CTR_W-32){wval[31]}}, wval};
        end else if (inc) begin
            st_d.cnt = st_q.cnt + 1'b1;
            ovf      = at_max;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !wr && at_max) |=> (cnt == '0)); // R9
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !wr) |=> $stable(cnt)); // R3
    AST_OVF_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (&cnt)); // R9

endmodule

// File: rtl/pmu_ctr_bank.sv
module pmu_ctr_bank
    import pmu_ctr_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int CTR_W   = 48,
    parameter int LANES   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [4:0]         reg_addr,
    input  logic [63:0]        reg_wdata,
    output logic [63:0]        reg_rdata,
    output logic               reg_err,
    input  logic [LANES-1:0]   evt_vld,
    input  logic [8*LANES-1:0] evt_code,
    input  logic [8*LANES-1:0] evt_umask,
    input  logic               priv_kernel,
    output logic [NUM_CTR-1:0] ovf_status,
    output logic               irq
);
    localparam int PAD_W = DATA_W - CTR_W;

    typedef struct packed {
        logic [NUM_CTR-1:0][SEL_W-1:0] evsel;
        logic [NUM_CTR-1:0]            glb;
        logic [NUM_CTR-1:0]            stat;
    } bank_t;

    bank_t st_d, st_q;

    region_e                       rgn;
    logic [2:0]                    sub;
    logic                          sub_ok;
    logic                          sel_bad;
    logic                          glb_bad;
    logic [NUM_CTR-1:0]            ctr_wr;
    logic [NUM_CTR-1:0]            hit_vec;
    logic [NUM_CTR-1:0]            ovf_vec;
    logic [NUM_CTR-1:0]            int_vec;
    logic [NUM_CTR-1:0][CTR_W-1:0] cnt_vec;
    logic [NUM_CTR-1:0]            clr_mask;

    assign rgn     = region_e'(reg_addr[4:3]);
    assign sub     = reg_addr[2:0];
    assign sub_ok  = (int'(sub) < NUM_CTR);
    assign sel_bad = (|reg_wdata[63:32]) || reg_wdata[SEL_RSVD];
    assign glb_bad = |(reg_wdata >> NUM_CTR);

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        pmu_evt_match #(.LANES(LANES)) u_match (
            .sel_code    (st_q.evsel[i][SEL_CODE_LO +: 8]),
            .sel_umask   (st_q.evsel[i][SEL_UMASK_LO +: 8]),
            .sel_usr     (st_q.evsel[i][SEL_USR]),
            .sel_os      (st_q.evsel[i][SEL_OS]),
            .sel_en      (st_q.evsel[i][SEL_EN]),
            .evt_vld     (evt_vld),
            .evt_code    (evt_code),
            .evt_umask   (evt_umask),
            .priv_kernel (priv_kernel),
            .hit         (hit_vec[i])
        );

        pmu_ctr_slice #(.CTR_W(CTR_W)) u_slice (
            .clk    (clk),
            .rst_n  (rst_n),
            .hit    (hit_vec[i]),
            .glb_en (st_q.glb[i]),
            .wr     (ctr_wr[i]),
            .wval   (reg_wdata[31:0]),
            .cnt    (cnt_vec[i]),
            .ovf    (ovf_vec[i])
        );

        assign int_vec[i] = st_q.evsel[i][SEL_INT];

        AST_STAT_SET: assert property (@(posedge clk) disable iff (!rst_n)
            ovf_vec[i] |=> st_q.stat[i]); // R9
    end

    // Next-state and write decode
    always_comb begin
        st_d     = st_q;
        reg_err  = 1'b0;
        ctr_wr   = '0;
        clr_mask = '0;
        if (reg_wr) begin
            unique case (rgn)
                RGN_CTR: begin
                    if (!sub_ok) reg_err = 1'b1;
                    for (int i = 0; i < NUM_CTR; i++)
                        if (sub_ok && int'(sub) == i) ctr_wr[i] = 1'b1;
                end
                RGN_SEL: begin
                    if (!sub_ok || sel_bad) reg_err = 1'b1;
                    for (int i = 0; i < NUM_CTR; i++)
                        if (sub_ok && !sel_bad && int'(sub) == i)
                            st_d.evsel[i] = reg_wdata[SEL_W-1:0];
                end
                RGN_GLOB: begin
                    if (sub == SUB_GLB_EN && !glb_bad)
                        st_d.glb = reg_wdata[NUM_CTR-1:0];
                    else if (sub == SUB_CLEAR)
                        clr_mask = reg_wdata[NUM_CTR-1:0];
                    else
                        reg_err = 1'b1;
                end
                default: reg_err = 1'b1;
            endcase
        end
        // a fresh overflow wins over a clear in the same cycle
        st_d.stat = (st_q.stat & ~clr_mask) | ovf_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Read mux
    always_comb begin
        reg_rdata = '0;
        unique case (rgn)
            RGN_CTR: begin
                for (int i = 0; i < NUM_CTR; i++)
                    if (int'(sub) == i) reg_rdata = {{PAD_W{1'b0}}, cnt_vec[i]};
            end
            RGN_SEL: begin
                for (int i = 0; i < NUM_CTR; i++)
                    if (int'(sub) == i) reg_rdata = {{(DATA_W-SEL_W){1'b0}}, st_q.evsel[i]};
            end
            RGN_GLOB: begin
                if (sub == SUB_GLB_EN)
                    reg_rdata = {{(DATA_W-NUM_CTR){1'b0}}, st_q.glb};
                else if (sub == SUB_STATUS)
                    reg_rdata = {{(DATA_W-NUM_CTR){1'b0}}, st_q.stat};
            end
            default: reg_rdata = '0;
        endcase
    end

    assign ovf_status = st_q.stat;
    assign irq        = |(st_q.stat & int_vec);

    AST_REJECT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        reg_err |=> ($stable(st_q.evsel) && $stable(st_q.glb))); // R7
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|ovf_status)); // R10

endmodule

// File: tb/sim_pmu_ctr_bank.sv
module sim_pmu_ctr_bank;
    localparam int NUM_CTR = 4;
    localparam int CTR_W   = 48;
    localparam int LANES   = 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               reg_wr = 1'b0;
    logic [4:0]         reg_addr = '0;
    logic [63:0]        reg_wdata = '0;
    logic [63:0]        reg_rdata;
    logic               reg_err;
    logic [LANES-1:0]   evt_vld = '0;
    logic [8*LANES-1:0] evt_code = '0;
    logic [8*LANES-1:0] evt_umask = '0;
    logic               priv_kernel = 1'b0;
    logic [NUM_CTR-1:0] ovf_status;
    logic               irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pmu_ctr_bank #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .LANES(LANES)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_err(reg_err),
        .evt_vld(evt_vld), .evt_code(evt_code), .evt_umask(evt_umask),
        .priv_kernel(priv_kernel), .ovf_status(ovf_status), .irq(irq)
    );

    typedef struct packed {
        logic        wr;
        logic [4:0]  addr;
        logic [63:0] wd;
        logic [63:0] exp;
        logic        exp_err;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 5'h10, 64'h0, 64'h0, 1'b0, 8'd1},                        // R1 global enable clear
        '{1'b1, 5'h08, 64'hFFDF_FFFF, 64'h0, 1'b0, 8'd7},                 // R7 legal, all stored bits
        '{1'b0, 5'h08, 64'h0, 64'hFFDF_FFFF, 1'b0, 8'd7},                 // R7 readback
        '{1'b1, 5'h08, 64'h1_0000_0000, 64'h0, 1'b1, 8'd7},               // R7 high bits refused
        '{1'b1, 5'h08, 64'h0020_0000, 64'h0, 1'b1, 8'd7},                 // R7 bit 21 refused
        '{1'b0, 5'h08, 64'h0, 64'hFFDF_FFFF, 1'b0, 8'd7},                 // R7 old value kept
        '{1'b1, 5'h08, 64'h0, 64'h0, 1'b0, 8'd7},
        '{1'b1, 5'h00, 64'h8000_0000, 64'h0, 1'b0, 8'd5},                 // R5
        '{1'b0, 5'h00, 64'h0, 64'h0000_FFFF_8000_0000, 1'b0, 8'd6},       // R6 R5 sign extension
        '{1'b1, 5'h00, 64'hFFFF_FFFF_1234_5678, 64'h0, 1'b0, 8'd5},       // R5 upper data ignored
        '{1'b0, 5'h00, 64'h0, 64'h1234_5678, 1'b0, 8'd5},
        '{1'b1, 5'h11, 64'h1, 64'h0, 1'b1, 8'd11},                        // R11 status read only
        '{1'b1, 5'h10, 64'h10, 64'h0, 1'b1, 8'd11},                       // R11 bit beyond NUM_CTR
        '{1'b1, 5'h10, 64'hF, 64'h0, 1'b0, 8'd11},
        '{1'b0, 5'h10, 64'h0, 64'hF, 1'b0, 8'd11},
        '{1'b1, 5'h04, 64'h0, 64'h0, 1'b1, 8'd11},                        // R11 unimplemented counter
        '{1'b1, 5'h00, 64'h0, 64'h0, 1'b0, 8'd5}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [4:0] a, input logic [63:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic pulse(input logic [1:0] v, input logic [7:0] c0, input logic [7:0] u0m,
                         input logic [7:0] c1, input logic [7:0] u1m, input logic kern);
        @(negedge clk);
        evt_vld = v; evt_code = {c1, c0}; evt_umask = {u1m, u0m}; priv_kernel = kern;
        @(negedge clk);
        evt_vld = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1", {62'h0, irq, |ovf_status}, 64'h0);

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            reg_addr = VEC[k].addr; reg_wdata = VEC[k].wd; reg_wr = VEC[k].wr;
            #1;
            if (VEC[k].wr) check($sformatf("R%0d vec%0d err", VEC[k].req, k), {63'h0, reg_err}, {63'h0, VEC[k].exp_err});
            else           check($sformatf("R%0d vec%0d data", VEC[k].req, k), reg_rdata, VEC[k].exp);
        end
        @(negedge clk); reg_wr = 1'b0;

        // R2 code and qualifier match
        wr(5'h08, 64'h0043_013C);
        repeat (3) pulse(2'b01, 8'h3C, 8'h01, 8'h00, 8'h00, 1'b0);
        rd_chk("R2", 5'h00, 64'd3);
        pulse(2'b01, 8'h3C, 8'h00, 8'h00, 8'h00, 1'b0);
        rd_chk("R2", 5'h00, 64'd3);
        pulse(2'b10, 8'h3C, 8'h01, 8'h3D, 8'h01, 1'b0);
        rd_chk("R2", 5'h00, 64'd3);
        // R12 two lanes hit at once
        pulse(2'b11, 8'h3C, 8'h01, 8'h3C, 8'h01, 1'b1);
        rd_chk("R12", 5'h00, 64'd4);

        // R4 privilege qualifiers
        wr(5'h09, 64'h0041_00C0);
        pulse(2'b01, 8'hC0, 8'h00, 8'h00, 8'h00, 1'b1);
        rd_chk("R4", 5'h01, 64'd0);
        pulse(2'b01, 8'hC0, 8'h00, 8'h00, 8'h00, 1'b0);
        rd_chk("R4", 5'h01, 64'd1);
        wr(5'h09, 64'h0042_00C0);
        pulse(2'b01, 8'hC0, 8'h00, 8'h00, 8'h00, 1'b0);
        rd_chk("R4", 5'h01, 64'd1);
        pulse(2'b01, 8'hC0, 8'h00, 8'h00, 8'h00, 1'b1);
        rd_chk("R4", 5'h01, 64'd2);

        // R3 both enables
        wr(5'h10, 64'hD);
        pulse(2'b01, 8'hC0, 8'h00, 8'h00, 8'h00, 1'b1);
        rd_chk("R3", 5'h01, 64'd2);
        wr(5'h10, 64'hF);
        wr(5'h09, 64'h0002_00C0);
        pulse(2'b01, 8'hC0, 8'h00, 8'h00, 8'h00, 1'b1);
        rd_chk("R3", 5'h01, 64'd2);

        // R8 pin-control bit inert
        wr(5'h0A, 64'h004B_0011);
        pulse(2'b01, 8'h11, 8'h00, 8'h00, 8'h00, 1'b0);
        rd_chk("R8", 5'h02, 64'd1);

        // R9 R10 overflow with interrupt
        wr(5'h0B, 64'h0053_0022);
        wr(5'h03, 64'hFFFF_FFFF);
        rd_chk("R6", 5'h03, 64'h0000_FFFF_FFFF_FFFF);
        check("R10", {63'h0, irq}, 64'h0);
        pulse(2'b01, 8'h22, 8'h00, 8'h00, 8'h00, 1'b1);
        rd_chk("R9", 5'h03, 64'h0);
        check("R9", {60'h0, ovf_status}, 64'h8);
        check("R10", {63'h0, irq}, 64'h1);
        rd_chk("R9", 5'h11, 64'h8);
        wr(5'h12, 64'h8);
        check("R11", {60'h0, ovf_status}, 64'h0);
        check("R11", {63'h0, irq}, 64'h0);

        // R10 overflow without interrupt
        wr(5'h02, 64'hFFFF_FFFF);
        pulse(2'b01, 8'h11, 8'h00, 8'h00, 8'h00, 1'b0);
        check("R10", {60'h0, ovf_status}, 64'h4);
        check("R10", {63'h0, irq}, 64'h0);
        wr(5'h12, 64'h4);

        // R5 write beats a same-cycle event
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 5'h00; reg_wdata = 64'd5;
        evt_vld = 2'b01; evt_code = {8'h00, 8'h3C}; evt_umask = {8'h00, 8'h01};
        @(negedge clk);
        reg_wr = 1'b0; evt_vld = '0;
        rd_chk("R5", 5'h00, 64'd5);

        // R1 reset clears state
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd_chk("R1", 5'h00, 64'h0);
        rd_chk("R1", 5'h08, 64'h0);
        rd_chk("R1", 5'h10, 64'h0);
        check("R1", {59'h0, irq, ovf_status}, 64'h0);

        finish_run();
    end
endmodule